// File: doc/BRIEF.md
# Rotating Triple-Pass Bitwise Logic Corrector

This block is an N-bit bitwise logic unit. It finds and repairs errors caused by a faulty bit-slice, using time instead of spare hardware. Each accepted operation runs on the same N slices up to three times:

- Pass one uses the operands as given.
- Pass two rotates both operands left by one position and rotates the slice outputs back right by one.
- Pass three, when it runs, does the same with a rotation of two.

A bitwise function commutes with rotation, so every aligned copy of the result should be identical. A bad slice corrupts a different aligned bit position in each pass. That lets the block detect the fault and, in correcting mode, repair it.

In detect-only mode the block always stops after two passes. It returns the first-pass result and flags any disagreement. In correcting mode, a permanent single-slice fault gives an adjacent pair of disagreeing bits, and the block repairs it after two passes. Any other disagreement starts a third pass, and a per-bit two-of-three vote gives the result. A fault-injection port can invert chosen slices during chosen passes, so that the repair paths can be exercised.

Top module: `rot_vote_logic`

## Requirements
- R1: After reset, `res`, `done`, `err_det`, `err_cor` and `sus_idx` are all zero.
- R2: `op_sel` selects the function applied to each bit pair: 0 = A AND B, 1 = A OR B, 2 = A XOR B, 3 = NOT A, 4 = A NAND B, 5 = A NOR B. With no fault injected, `res` equals that function of the operands and both error flags are low.
- R3: `op_sel` codes 6 and 7 give `res` = 0 with both error flags low and completion after two passes, even when faults are being injected.
- R4: A `start` sampled high while the unit is idle launches an operation and latches all inputs. `done` is a one-cycle pulse after the second rising edge following that sample for a two-pass outcome, or after the third edge for a three-pass outcome. The outputs then hold until the next completion.
- R5: A `start` that arrives while an operation is in progress is ignored. The running operation completes with its original inputs, and no extra completion follows.
- R6: Bit i of `flt_mask` inverts the output of slice i during every pass whose bit is set in `flt_pass` (bit 0 = pass one, bit 1 = pass two, bit 2 = pass three). A fault in a pass that does not run has no effect.
- R7: With `corr_en` = 0, the unit always runs two passes and returns the first-pass result. `err_det` is high exactly when the two aligned results differ, and `err_cor` is low.
- R8: With `corr_en` = 1, if the two aligned results differ in exactly the positions i and i-1 (modulo N, so slice 0 pairs with position N-1), bit i of the first-pass result is inverted. Completion comes after two passes, with `err_det` and `err_cor` high.
- R9: With `corr_en` = 1, any other nonzero disagreement after two passes starts a third pass. `res` is then the per-bit majority of the three aligned results, `err_det` is high, and `err_cor` is high exactly when that majority differs from the first-pass result.
- R10: `sus_idx` is the lowest aligned bit position at which any two of the finished passes disagree. It is 0 when `err_det` is low.
- R11: With `corr_en` = 1 and two agreeing passes, the unit completes after two passes with the first-pass result and both flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launch strobe, sampled only when idle |
| op_sel | input | 3 | Bitwise function code |
| opnd_a | input | N | First operand |
| opnd_b | input | N | Second operand |
| corr_en | input | 1 | 1 = correcting mode, 0 = detect-only mode |
| flt_mask | input | N | Slices whose output is inverted |
| flt_pass | input | 3 | Passes during which the mask applies |
| res | output | N | Final result |
| done | output | 1 | One-cycle completion pulse |
| err_det | output | 1 | A disagreement between passes was seen |
| err_cor | output | 1 | The returned result differs from pass one |
| sus_idx | output | clog2(N) | Lowest disagreeing aligned bit position |

## Verification
The bench aims at the rotation wrap-around. A fault in slice 0 must pair with position N-1. A design that rotates the wrong way, or forgets the modulo, would invert the wrong bit or fall into a needless third pass, visible as a wrong result or a late `done`.

Faults confined to a single pass (only pass one, or only pass two) give a one-bit disagreement. A design that tried to fix that after two passes would return a wrong bit or a wrong `err_cor`.

Two non-adjacent faulty slices force the full vote with a mask that also hits pass three. A misaligned third rotation would outvote the correct copy.

Invalid codes under heavy injection, a fault aimed at a pass that never runs, and a second `start` during a run complete the set. Each of them catches designs that leak faults or restart mid-operation.

// File: rtl/rvl_pkg.sv
package rvl_pkg;

    localparam logic [2:0] OP_AND  = 3'd0;
    localparam logic [2:0] OP_OR   = 3'd1;
    localparam logic [2:0] OP_XOR  = 3'd2;
    localparam logic [2:0] OP_NOTA = 3'd3;
    localparam logic [2:0] OP_NAND = 3'd4;
    localparam logic [2:0] OP_NOR  = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_P1   = 2'd1,
        ST_P2   = 2'd2,
        ST_P3   = 2'd3
    } seq_e;

    // control fields captured at launch
    typedef struct packed {
        logic [2:0] op;
        logic       corr_mode;
        logic [2:0] flt_pass;
    } job_t;

    function automatic logic op_valid(input logic [2:0] op);
        return op <= OP_NOR;
    endfunction

    function automatic logic slice_fn(input logic [2:0] op, input logic a, input logic b);
        case (op)
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            OP_NOTA: return ~a;
            OP_NAND: return ~(a & b);
            OP_NOR:  return ~(a | b);
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rvl_rot.sv
// Circular rotation by 0, 1 or 2 positions; LEFT selects direction.
module rvl_rot #(
    parameter int N    = 8,
    parameter bit LEFT = 1'b1
) (
    input  logic [N-1:0] din,
    input  logic [1:0]   amt,
    output logic [N-1:0] dout
);
    for (genvar j = 0; j < N; j++) begin : g_bit
        localparam int SRC1 = LEFT ? (j + N - 1) % N : (j + 1) % N;
        localparam int SRC2 = LEFT ? (j + N - 2) % N : (j + 2) % N;
        assign dout[j] = (amt == 2'd1) ? din[SRC1] :
                         (amt == 2'd2) ? din[SRC2] : din[j];
    end
endmodule

// File: rtl/rvl_slices.sv
// N identical one-bit logic slices with per-slice output inversion.
module rvl_slices
    import rvl_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [2:0]   op,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] flt,
    output logic [N-1:0] y
);
    logic vld;
    assign vld = op_valid(op);

    for (genvar i = 0; i < N; i++) begin : g_slice
        assign y[i] = vld & (slice_fn(op, a[i], b[i]) ^ flt[i]);
    end
endmodule

// File: rtl/rvl_vote.sv
// Majority, disagreement map and adjacent-pair finder over aligned copies.
module rvl_vote #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  x,
    input  logic [N-1:0]  y,
    input  logic [N-1:0]  z,
    output logic [N-1:0]  maj,
    output logic [N-1:0]  diff,
    output logic [IW-1:0] low_idx,
    output logic          pair_hit,
    output logic [IW-1:0] pair_idx
);
    logic [N-1:0] dxy;
    logic [N-1:0] adj;

    assign dxy  = x ^ y;
    assign maj  = (x & y) | (x & z) | (y & z);
    assign diff = dxy | (x ^ z) | (y ^ z);

    // adj[i]: positions i and i-1 (mod N) both disagree
    for (genvar i = 0; i < N; i++) begin : g_adj
        localparam int PRV = (i + N - 1) % N;
        assign adj[i] = dxy[i] & dxy[PRV];
    end

    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (diff[i]) low_idx = IW'(i);
        end
    end

    always_comb begin
        pair_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (adj[i]) pair_idx = IW'(i);
        end
    end

    assign pair_hit = ($countones(dxy) == 2) && (|adj);
endmodule

// File: rtl/rot_vote_logic.sv
module rot_vote_logic
    import rvl_pkg::*;
#(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [2:0]    op_sel,
    input  logic [N-1:0]  opnd_a,
    input  logic [N-1:0]  opnd_b,
    input  logic          corr_en,
    input  logic [N-1:0]  flt_mask,
    input  logic [2:0]    flt_pass,
    output logic [N-1:0]  res,
    output logic          done,
    output logic          err_det,
    output logic          err_cor,
    output logic [IW-1:0] sus_idx
);
    seq_e         st;
    job_t         job;
    logic [N-1:0] a_q, b_q, fm_q;
    logic [N-1:0] r1_q, r2_q;

    logic [1:0]   amt;
    logic         pass_flt;
    logic [N-1:0] a_rot, b_rot, slc_out, cur;
    logic [N-1:0] vy, maj, diff, flip;
    logic [IW-1:0] low_idx, pair_idx;
    logic         pair_hit, finish2;

    always_comb begin
        case (st)
            ST_P2:   amt = 2'd1;
            ST_P3:   amt = 2'd2;
            default: amt = 2'd0;
        endcase
        pass_flt = ((st == ST_P1) & job.flt_pass[0]) |
                   ((st == ST_P2) & job.flt_pass[1]) |
                   ((st == ST_P3) & job.flt_pass[2]);
    end

    rvl_rot #(.N(N), .LEFT(1'b1)) u_rot_a (.din(a_q), .amt(amt), .dout(a_rot));
    rvl_rot #(.N(N), .LEFT(1'b1)) u_rot_b (.din(b_q), .amt(amt), .dout(b_rot));

    rvl_slices #(.N(N)) u_slices (
        .op  (job.op),
        .a   (a_rot),
        .b   (b_rot),
        .flt (pass_flt ? fm_q : '0),
        .y   (slc_out)
    );

    rvl_rot #(.N(N), .LEFT(1'b0)) u_align (.din(slc_out), .amt(amt), .dout(cur));

    // pass two compares r1 against the live copy; pass three votes all three
    assign vy = (st == ST_P3) ? r2_q : cur;

    rvl_vote #(.N(N)) u_vote (
        .x        (r1_q),
        .y        (vy),
        .z        (cur),
        .maj      (maj),
        .diff     (diff),
        .low_idx  (low_idx),
        .pair_hit (pair_hit),
        .pair_idx (pair_idx)
    );

    assign flip    = {{(N-1){1'b0}}, 1'b1} << pair_idx;
    assign finish2 = !job.corr_mode || (diff == '0) || pair_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            job     <= '0;
            a_q     <= '0;
            b_q     <= '0;
            fm_q    <= '0;
            r1_q    <= '0;
            r2_q    <= '0;
            res     <= '0;
            done    <= 1'b0;
            err_det <= 1'b0;
            err_cor <= 1'b0;
            sus_idx <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        job  <= '{op: op_sel, corr_mode: corr_en, flt_pass: flt_pass};
                        a_q  <= opnd_a;
                        b_q  <= opnd_b;
                        fm_q <= flt_mask;
                        st   <= ST_P1;
                    end
                end
                ST_P1: begin
                    r1_q <= cur;
                    st   <= ST_P2;
                end
                ST_P2: begin
                    if (finish2) begin
                        res     <= (job.corr_mode && pair_hit) ? (r1_q ^ flip) : r1_q;
                        err_det <= |diff;
                        err_cor <= job.corr_mode && pair_hit;
                        sus_idx <= low_idx;
                        done    <= 1'b1;
                        st      <= ST_IDLE;
                    end else begin
                        r2_q <= cur;
                        st   <= ST_P3;
                    end
                end
                default: begin
                    res     <= maj;
                    err_det <= |diff;
                    err_cor <= |(maj ^ r1_q);
                    sus_idx <= low_idx;
                    done    <= 1'b1;
                    st      <= ST_IDLE;
                end
            endcase
        end
    end

    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
        (start && st != ST_IDLE) |=> ($stable(a_q) && $stable(b_q) && $stable(job)));

    assert_detect_mode_no_cor_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !job.corr_mode) |-> !err_cor);

    assert_cor_implies_det_R9: assert property (@(posedge clk) disable iff (rst)
        err_cor |-> err_det);

    assert_clean_result_R11: assert property (@(posedge clk) disable iff (rst)
        (done && !err_det) |-> (res == r1_q && sus_idx == '0));

endmodule

// File: tb/rot_vote_logic_tb.sv
module rot_vote_logic_tb;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [2:0]    op_sel;
    logic [N-1:0]  opnd_a, opnd_b, flt_mask;
    logic          corr_en;
    logic [2:0]    flt_pass;
    logic [N-1:0]  res;
    logic          done, err_det, err_cor;
    logic [IW-1:0] sus_idx;

    int n_chk  = 0;
    int n_fail = 0;
    bit all_done = 1'b0;

    always #5 clk = ~clk;

    rot_vote_logic #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .start(start), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .corr_en(corr_en),
        .flt_mask(flt_mask), .flt_pass(flt_pass),
        .res(res), .done(done), .err_det(err_det), .err_cor(err_cor),
        .sus_idx(sus_idx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] ref_op(input logic [2:0] op, input logic [N-1:0] a, input logic [N-1:0] b);
        case (op)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a ^ b;
            3'd3: return ~a;
            3'd4: return ~(a & b);
            3'd5: return ~(a | b);
            default: return '0;
        endcase
    endfunction

    function automatic logic [N-1:0] rotr(input logic [N-1:0] v, input int s);
        logic [N-1:0] r = v;
        for (int k = 0; k < s; k++) r = {r[0], r[N-1:1]};
        return r;
    endfunction

    function automatic logic [IW-1:0] lowest(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return IW'(i);
        return '0;
    endfunction

    // expected outcome derived from the requirements
    task automatic predict(input logic [2:0] op, input logic [N-1:0] a, input logic [N-1:0] b,
                           input logic md, input logic [N-1:0] fm, input logic [2:0] fp,
                           output logic [N-1:0] er, output logic ed, output logic ec,
                           output logic [IW-1:0] es, output int np);
        logic [N-1:0] t, e1, e2, e3, d, mj, un;
        logic vld;
        int pi;
        vld = (op <= 3'd5);
        t  = ref_op(op, a, b);
        e1 = t ^ ((vld && fp[0]) ? fm : '0);           // R6 slice i -> aligned bit i
        e2 = t ^ ((vld && fp[1]) ? rotr(fm, 1) : '0);  // -> aligned bit i-1
        e3 = t ^ ((vld && fp[2]) ? rotr(fm, 2) : '0);  // -> aligned bit i-2
        d  = e1 ^ e2;
        pi = -1;
        for (int i = 0; i < N; i++)
            if (d == ((N'(1) << i) | (N'(1) << ((i + N - 1) % N)))) pi = i;
        if (!md || d == '0) begin
            np = 2; er = e1; ed = |d; ec = 1'b0; es = lowest(d);
        end else if (pi >= 0) begin
            np = 2; er = e1 ^ (N'(1) << pi); ed = 1'b1; ec = 1'b1; es = lowest(d);
        end else begin
            mj = (e1 & e2) | (e1 & e3) | (e2 & e3);
            un = d | (e1 ^ e3) | (e2 ^ e3);
            np = 3; er = mj; ed = 1'b1; ec = |(mj ^ e1); es = lowest(un);
        end
    endtask

    task automatic run_op(input string tag, input logic [2:0] op, input logic [N-1:0] a,
                          input logic [N-1:0] b, input logic md, input logic [N-1:0] fm,
                          input logic [2:0] fp);
        logic [N-1:0] er; logic ed, ec; logic [IW-1:0] es; int np;
        predict(op, a, b, md, fm, fp, er, ed, ec, es, np);
        @(negedge clk);
        start = 1'b1; op_sel = op; opnd_a = a; opnd_b = b;
        corr_en = md; flt_mask = fm; flt_pass = fp;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < np - 1; k++) begin
            @(negedge clk);
            chk({tag, " R4 done early"}, 32'(done), 32'd0);
        end
        @(negedge clk);
        chk({tag, " R4 done"}, 32'(done), 32'd1);
        chk({tag, " res"}, 32'(res), 32'(er));
        chk({tag, " err_det"}, 32'(err_det), 32'(ed));
        chk({tag, " err_cor"}, 32'(err_cor), 32'(ec));
        chk({tag, " R10 sus_idx"}, 32'(sus_idx), 32'(es));
        @(negedge clk);
        chk({tag, " R4 done pulse"}, 32'(done), 32'd0);
        chk({tag, " R4 res held"}, 32'(res), 32'(er));
    endtask

    task automatic t_reset();
        chk("R1 res", 32'(res), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 err_det", 32'(err_det), 32'd0);
        chk("R1 err_cor", 32'(err_cor), 32'd0);
        chk("R1 sus_idx", 32'(sus_idx), 32'd0);
    endtask

    task automatic t_ops();
        for (int o = 0; o < 6; o++) begin
            run_op("R2 pat1", 3'(o), 8'hC5, 8'h9A, 1'b1, '0, 3'b000);
            run_op("R2 pat2", 3'(o), 8'h0F, 8'hF3, 1'b0, '0, 3'b000);
        end
    endtask

    task automatic t_invalid();
        run_op("R3 code6", 3'd6, 8'hFF, 8'hFF, 1'b1, 8'hFF, 3'b111);
        run_op("R3 code7", 3'd7, 8'h5A, 8'hA5, 1'b1, 8'h11, 3'b011);
    endtask

    task automatic t_pass_gate();
        run_op("R6 no pass", 3'd1, 8'h3C, 8'h41, 1'b0, 8'h10, 3'b000);
        run_op("R6 pass3 only", 3'd2, 8'h3C, 8'h41, 1'b0, 8'h10, 3'b100);
    endtask

    task automatic t_detect();
        run_op("R7 slice3", 3'd0, 8'hFF, 8'hAA, 1'b0, 8'h08, 3'b011);
        run_op("R7 pass2 only", 3'd1, 8'h00, 8'h00, 1'b0, 8'h40, 3'b010);
    endtask

    task automatic t_pair();
        run_op("R8 slice3", 3'd2, 8'h6C, 8'h35, 1'b1, 8'h08, 3'b011);
        run_op("R8 slice0 wrap", 3'd0, 8'hFF, 8'hFF, 1'b1, 8'h01, 3'b111);
        run_op("R8 sliceN-1", 3'd5, 8'h12, 8'h40, 1'b1, 8'h80, 3'b011);
    endtask

    task automatic t_third();
        run_op("R9 pass1 only", 3'd4, 8'hF0, 8'hCC, 1'b1, 8'h20, 3'b001);
        run_op("R9 pass2 only", 3'd3, 8'h96, 8'h00, 1'b1, 8'h20, 3'b010);
        run_op("R9 two slices", 3'd1, 8'h81, 8'h24, 1'b1, 8'h24, 3'b111);
    endtask

    task automatic t_clean();
        run_op("R11 clean", 3'd2, 8'hA5, 8'h5A, 1'b1, '0, 3'b111);
    endtask

    task automatic t_busy();
        @(negedge clk);
        start = 1'b1; op_sel = 3'd0; opnd_a = 8'hF0; opnd_b = 8'hFF;
        corr_en = 1'b1; flt_mask = '0; flt_pass = 3'b000;
        @(negedge clk);
        op_sel = 3'd1; opnd_a = 8'h0F; opnd_b = 8'h00;   // second start while running
        @(negedge clk);
        start = 1'b0;
        chk("R5 no early done", 32'(done), 32'd0);
        @(negedge clk);
        chk("R5 done", 32'(done), 32'd1);
        chk("R5 res from first", 32'(res), 32'h00F0);
        @(negedge clk);
        chk("R5 no second done", 32'(done), 32'd0);
        @(negedge clk);
        chk("R5 still idle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!all_done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_sel = '0; opnd_a = '0; opnd_b = '0;
        corr_en = 1'b0; flt_mask = '0; flt_pass = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ops();
        t_invalid();
        t_pass_gate();
        t_detect();
        t_pair();
        t_third();
        t_clean();
        t_busy();
        all_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule